// File: doc/BRIEF.md
# Legacy PCI Configuration Port Decoder

This block is the I/O-space slave behind the classic two-register configuration mechanism. It answers accesses to eight consecutive byte offsets. The low four offsets hold a 32-bit selection register. The high four offsets form a window onto one dword of the configuration space of the function that the selection register names. Each access carries a byte offset, a byte count of 1 to 4, and data packed into the low byte lanes. The block keeps the selection register and merges partial writes into it. It splits the register into bus, device, function and dword index, and turns window accesses into byte-enabled requests on a downstream configuration port.

The downstream side answers reads in the same cycle through `cfg_rsp_rdata`. Read results come back on the access side one cycle after the read was presented, shifted down so that the first addressed byte sits in lane 0. A one-byte write with a particular bit pattern is not stored. It is turned into a single-cycle platform reset request. A strap input can silence every read.

Top module: `pcicfg_port`

## Requirements
- R1: After reset the selection register holds zero, and `acc_rvalid` and `plat_reset_req` are low.
- R2: A write at offsets 0..3 of 1, 2 or 4 bytes that stays inside the dword replaces only the addressed byte lanes (little-endian) and keeps the rest. A write of any other length, or one that crosses the dword end, leaves the register unchanged. Writing 0x11223344 at offset 0 and then 0x55AA (2 bytes) at offset 2 leaves 0x55AA3344.
- R3: A read at offsets 0..3 returns the register shifted right by 8 times (offset mod 4), with lanes at or above the length forced to zero. If (offset mod 4) plus the length exceeds 4, or the length is 0, the read returns 0xFFFFFFFF.
- R4: Offsets 8 and above read as 0xFFFFFFFF, and writes to them change nothing.
- R5: Bit 31 of the selection register is the enable. While it is 0, window reads return 0xFFFFFFFF and window accesses issue no downstream request.
- R6: The downstream request carries bus = bits 23:16, device = bits 15:11, function = bits 10:8 and dword index = bits 7:2 of the register. Bits 30:24 and 1:0 have no effect on the request.
- R7: An enabled window write issues one request in the same cycle. Its byte enables cover lanes (offset mod 4) up to (offset mod 4 + length - 1), and the data is shifted up to those lanes. A window write that crosses the dword end, or has length 0, issues no request.
- R8: An enabled window read issues a read request and returns the downstream dword aligned as in R3. A crossing window read returns 0xFFFFFFFF and issues no request.
- R9: A one-byte write at offset 1 whose data has bit 2 set raises `plat_reset_req` for exactly one cycle, on the cycle after the write, and does not change the register. A one-byte write at offset 1 with bit 2 clear updates byte 1 normally.
- R10: While `port_disable` is high, every read returns 0xFFFFFFFF and issues no downstream read. Writes still take effect.
- R11: Every read produces `acc_rvalid` high for exactly the following cycle, and writes produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_disable | input | 1 | Strap: force all reads to all-ones |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | OFFS_W | Byte offset of the access |
| acc_len | input | 3 | Byte count |
| acc_wdata | input | 32 | Write data, packed from lane 0 |
| acc_rvalid | output | 1 | Read result valid |
| acc_rdata | output | 32 | Read result, first byte in lane 0 |
| cfg_req_valid | output | 1 | Downstream request |
| cfg_req_write | output | 1 | Downstream request is a write |
| cfg_req_bus | output | 8 | Target bus |
| cfg_req_dev | output | 5 | Target device |
| cfg_req_func | output | 3 | Target function |
| cfg_req_reg | output | 6 | Target dword index |
| cfg_req_be | output | 4 | Byte enables |
| cfg_req_wdata | output | 32 | Lane-aligned write data |
| cfg_rsp_rdata | input | 32 | Same-cycle downstream read data |
| plat_reset_req | output | 1 | One-cycle platform reset request |

## Verification
The assertions assume that the access inputs carry known values whenever `acc_valid` is high and that an access lasts exactly one cycle. They also assume that the downstream returns its read dword in the cycle of the request and never stalls. The stimulus drives one single-cycle access at a time on the falling edge, keeps `acc_valid` low between accesses and holds `port_disable` steady across each access. The downstream model answers from a small array, combinationally, in the same cycle.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
    localparam int DW      = 32;
    localparam int NB      = DW / 8;
    localparam int SW      = $clog2(NB);
    localparam int LEN_W   = 3;
    localparam int BUS_W   = 8;
    localparam int DEV_W   = 5;
    localparam int FN_W    = 3;
    localparam int REG_W   = 6;
    localparam int REG_LO  = 2;
    localparam int FN_LO   = REG_LO + REG_W;
    localparam int DEV_LO  = FN_LO + FN_W;
    localparam int BUS_LO  = DEV_LO + DEV_W;
    localparam int BUS_HI  = BUS_LO + BUS_W - 1;
    localparam int EN_BIT  = DW - 1;
    localparam int RST_OFFS = 1;
    localparam int RST_BIT  = 2;

    typedef struct packed {
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
        logic [REG_W-1:0] reg_idx;
    } cfg_target_t;

    typedef struct packed {
        logic [DW-1:0] addr;
        logic          rvalid;
        logic [DW-1:0] rdata;
        logic          rst_pulse;
    } port_state_t;

    function automatic logic span_fits(logic [SW-1:0] start, logic [LEN_W-1:0] len);
        return (len != '0) && ((int'(start) + int'(len)) <= NB);
    endfunction

    function automatic logic [NB-1:0] lane_mask(logic [SW-1:0] start, logic [LEN_W-1:0] len);
        logic [NB-1:0] m;
        for (int i = 0; i < NB; i++) begin
            m[i] = (i >= int'(start)) && (i < int'(start) + int'(len));
        end
        return m;
    endfunction
endpackage

// File: rtl/pcicfg_lane_merge.sv
module pcicfg_lane_merge
    import pcicfg_pkg::*;
(
    input  logic [DW-1:0]    cur,
    input  logic [SW-1:0]    start,
    input  logic [LEN_W-1:0] len,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    merged,
    output logic             accept
);
    logic [DW-1:0] shifted;
    logic [NB-1:0] mask;

    always_comb begin
        shifted = wdata << {start, 3'b000};
        mask    = lane_mask(start, len);
        accept  = ((len == LEN_W'(1)) || (len == LEN_W'(2)) || (len == LEN_W'(4)))
                  && span_fits(start, len);
    end

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign merged[8*b +: 8] = (accept && mask[b]) ? shifted[8*b +: 8] : cur[8*b +: 8];
    end
endmodule

// File: rtl/pcicfg_target_decode.sv
module pcicfg_target_decode
    import pcicfg_pkg::*;
(
    input  logic [BUS_HI:REG_LO] sel,
    output cfg_target_t          tgt
);
    always_comb begin
        tgt.bus     = sel[BUS_LO +: BUS_W];
        tgt.dev     = sel[DEV_LO +: DEV_W];
        tgt.fn      = sel[FN_LO  +: FN_W];
        tgt.reg_idx = sel[REG_LO +: REG_W];
    end
endmodule

// File: rtl/pcicfg_read_align.sv
module pcicfg_read_align
    import pcicfg_pkg::*;
(
    input  logic [DW-1:0]    value,
    input  logic [SW-1:0]    start,
    input  logic [LEN_W-1:0] len,
    output logic [DW-1:0]    aligned
);
    logic [DW-1:0] shifted;
    assign shifted = value >> {start, 3'b000};

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign aligned[8*b +: 8] = (b < int'(len)) ? shifted[8*b +: 8] : 8'h00;
    end
endmodule

// File: rtl/pcicfg_port.sv
module pcicfg_port
    import pcicfg_pkg::*;
#(
    parameter int OFFS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_disable,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [OFFS_W-1:0] acc_offset,
    input  logic [LEN_W-1:0]  acc_len,
    input  logic [DW-1:0]     acc_wdata,
    output logic              acc_rvalid,
    output logic [DW-1:0]     acc_rdata,
    output logic              cfg_req_valid,
    output logic              cfg_req_write,
    output logic [BUS_W-1:0]  cfg_req_bus,
    output logic [DEV_W-1:0]  cfg_req_dev,
    output logic [FN_W-1:0]   cfg_req_func,
    output logic [REG_W-1:0]  cfg_req_reg,
    output logic [NB-1:0]     cfg_req_be,
    output logic [DW-1:0]     cfg_req_wdata,
    input  logic [DW-1:0]     cfg_rsp_rdata,
    output logic              plat_reset_req
);
    localparam int WIN_END = 2 * NB;

    port_state_t st_d, st_q;

    logic [SW-1:0] lane_start;
    logic          in_addr, in_win, fits_dw, merge_ok, rst_cmd, win_en;
    logic [DW-1:0] merged, align_src, aligned;
    cfg_target_t   tgt;

    assign lane_start = acc_offset[SW-1:0];
    assign win_en     = st_q.addr[EN_BIT];

    always_comb begin
        in_addr = int'(acc_offset) < NB;
        in_win  = !in_addr && (int'(acc_offset) < WIN_END);
        fits_dw = span_fits(lane_start, acc_len);
        rst_cmd = acc_valid && acc_write
                  && (acc_offset == OFFS_W'(RST_OFFS))
                  && (acc_len == LEN_W'(1))
                  && acc_wdata[RST_BIT];
    end

    pcicfg_lane_merge u_merge (
        .cur    (st_q.addr),
        .start  (lane_start),
        .len    (acc_len),
        .wdata  (acc_wdata),
        .merged (merged),
        .accept (merge_ok)
    );

    pcicfg_target_decode u_decode (
        .sel (st_q.addr[BUS_HI:REG_LO]),
        .tgt (tgt)
    );

    assign align_src = in_addr ? st_q.addr : cfg_rsp_rdata;

    pcicfg_read_align u_align (
        .value   (align_src),
        .start   (lane_start),
        .len     (acc_len),
        .aligned (aligned)
    );

    // Downstream request, same cycle as the access
    always_comb begin
        cfg_req_valid = acc_valid && in_win && win_en && fits_dw
                        && (acc_write || !port_disable);
        cfg_req_write = acc_write;
        cfg_req_bus   = tgt.bus;
        cfg_req_dev   = tgt.dev;
        cfg_req_func  = tgt.fn;
        cfg_req_reg   = tgt.reg_idx;
        cfg_req_be    = lane_mask(lane_start, acc_len);
        cfg_req_wdata = acc_wdata << {lane_start, 3'b000};
    end

    // Next-state computation
    always_comb begin
        st_d           = st_q;
        st_d.rvalid    = 1'b0;
        st_d.rst_pulse = rst_cmd;
        if (acc_valid && acc_write && in_addr && !rst_cmd && merge_ok) begin
            st_d.addr = merged;
        end
        if (acc_valid && !acc_write) begin
            st_d.rvalid = 1'b1;
            if (port_disable || !fits_dw) begin
                st_d.rdata = '1;
            end else if (in_addr) begin
                st_d.rdata = aligned;
            end else if (in_win && win_en) begin
                st_d.rdata = aligned;
            end else begin
                st_d.rdata = '1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_rvalid     = st_q.rvalid;
    assign acc_rdata      = st_q.rdata;
    assign plat_reset_req = st_q.rst_pulse;

    // Read response timing
    p_rvalid_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> acc_rvalid);
    p_rvalid_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rvalid |-> $past(acc_valid && !acc_write));

    // Reset command decode
    p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        plat_reset_req |-> $past(acc_valid && acc_write && (acc_len == LEN_W'(1))
                                 && (acc_offset == OFFS_W'(RST_OFFS))));
    p_pulse_keeps_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        plat_reset_req |-> (st_q.addr == $past(st_q.addr)));

    // Selection register only moves on writes
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_valid && acc_write) |-> (st_q.addr == $past(st_q.addr)));

    // Downstream gating
    p_req_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> st_q.addr[EN_BIT]);
    p_be_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> (cfg_req_be != '0));
    p_strap_no_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (port_disable && cfg_req_valid) |-> cfg_req_write);
    p_strap_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rvalid && $past(port_disable)) |-> (acc_rdata == '1));
endmodule

// File: tb/pcicfg_port_tb_top.sv
module pcicfg_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_disable = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [3:0]  acc_offset = '0;
    logic [2:0]  acc_len = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_rvalid;
    logic [31:0] acc_rdata;
    logic        cfg_req_valid, cfg_req_write;
    logic [7:0]  cfg_req_bus;
    logic [4:0]  cfg_req_dev;
    logic [2:0]  cfg_req_func;
    logic [5:0]  cfg_req_reg;
    logic [3:0]  cfg_req_be;
    logic [31:0] cfg_req_wdata;
    logic [31:0] cfg_rsp_rdata;
    logic        plat_reset_req;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pcicfg_port dut_i (
        .clk(clk), .rst_n(rst_n), .port_disable(port_disable),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_offset(acc_offset),
        .acc_len(acc_len), .acc_wdata(acc_wdata),
        .acc_rvalid(acc_rvalid), .acc_rdata(acc_rdata),
        .cfg_req_valid(cfg_req_valid), .cfg_req_write(cfg_req_write),
        .cfg_req_bus(cfg_req_bus), .cfg_req_dev(cfg_req_dev),
        .cfg_req_func(cfg_req_func), .cfg_req_reg(cfg_req_reg),
        .cfg_req_be(cfg_req_be), .cfg_req_wdata(cfg_req_wdata),
        .cfg_rsp_rdata(cfg_rsp_rdata), .plat_reset_req(plat_reset_req)
    );

    // Downstream model
    logic [31:0] mem [64];
    int          req_cnt = 0;
    logic [7:0]  last_bus;
    logic [4:0]  last_dev;
    logic [2:0]  last_fn;
    logic [5:0]  last_reg;
    logic [3:0]  last_be;
    logic [31:0] last_wdata;

    initial for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 | i;
    assign cfg_rsp_rdata = mem[cfg_req_reg];

    always @(posedge clk) begin
        if (cfg_req_valid) begin
            req_cnt    <= req_cnt + 1;
            last_bus   <= cfg_req_bus;
            last_dev   <= cfg_req_dev;
            last_fn    <= cfg_req_func;
            last_reg   <= cfg_req_reg;
            last_be    <= cfg_req_be;
            last_wdata <= cfg_req_wdata;
            if (cfg_req_write)
                for (int b = 0; b < 4; b++)
                    if (cfg_req_be[b]) mem[cfg_req_reg][8*b +: 8] <= cfg_req_wdata[8*b +: 8];
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Scoreboard for read results
    logic [31:0] exp_q[$];
    string       tag_q[$];
    int          pulses = 0;
    bit          prev_pulse = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (acc_rvalid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11 unexpected rvalid", 32'h1, 32'h0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(acc_rdata === e, t, acc_rdata, e);
                end
            end
            if (plat_reset_req) begin
                pulses++;
                if (prev_pulse) check(1'b0, "R9 pulse longer than one cycle", 32'h2, 32'h1);
            end
            prev_pulse = plat_reset_req;
        end
    end

    task automatic access(input bit wr, input int offs, input int len, input logic [31:0] data);
        @(negedge clk);
        acc_valid  = 1'b1;
        acc_write  = wr;
        acc_offset = offs[3:0];
        acc_len    = len[2:0];
        acc_wdata  = data;
        @(negedge clk);
        acc_valid  = 1'b0;
    endtask

    task automatic rd(input int offs, input int len, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        access(1'b0, offs, len, 32'h0);
    endtask

    task automatic idle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 32'h0, 32'h1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(acc_rvalid == 1'b0, "R1 rvalid after reset", {31'h0, acc_rvalid}, 32'h0);
        check(plat_reset_req == 1'b0, "R1 reset request after reset", {31'h0, plat_reset_req}, 32'h0);
        rd(0, 4, 32'h0000_0000, "R1 register after reset");

        // R2 byte-lane merge
        access(1'b1, 0, 4, 32'h1122_3344);
        access(1'b1, 2, 2, 32'h0000_55AA);
        rd(0, 4, 32'h55AA_3344, "R2 merged register");
        // R3 aligned reads and crossing
        rd(2, 2, 32'h0000_55AA, "R3 upper half read");
        rd(1, 1, 32'h0000_0033, "R3 single byte read");
        rd(3, 2, 32'hFFFF_FFFF, "R3 crossing read");
        // R2 illegal lengths / crossing write ignored
        access(1'b1, 0, 3, 32'h0077_7777);
        access(1'b1, 3, 2, 32'h0000_9999);
        rd(0, 4, 32'h55AA_3344, "R2 ignored writes");

        // R9 reset command
        access(1'b1, 1, 1, 32'h0000_0004);
        idle();
        check(pulses == 1, "R9 reset pulse count", pulses, 1);
        rd(0, 4, 32'h55AA_3344, "R9 register unchanged by reset command");
        access(1'b1, 1, 1, 32'h0000_0008);
        idle();
        check(pulses == 1, "R9 no pulse without bit 2", pulses, 1);
        rd(0, 4, 32'h55AA_0844, "R9 plain byte write at offset 1");

        // R4 unmapped offsets
        rd(8, 4, 32'hFFFF_FFFF, "R4 unmapped read");
        access(1'b1, 9, 1, 32'h0000_0012);
        rd(0, 4, 32'h55AA_0844, "R4 unmapped write has no effect");

        // R5 enable clear
        base = req_cnt;
        rd(4, 4, 32'hFFFF_FFFF, "R5 window read while disabled");
        access(1'b1, 4, 4, 32'h1234_5678);
        idle();
        check(req_cnt == base, "R5 no downstream request", req_cnt, base);

        // R6/R7 decode and window write (bits 30:24 and 1:0 set)
        access(1'b1, 0, 4, 32'hFF12_2B33);
        access(1'b1, 4, 4, 32'hCAFE_F00D);
        idle();
        check(req_cnt == base + 1, "R7 one write request", req_cnt, base + 1);
        check(last_bus == 8'h12, "R6 bus field", {24'h0, last_bus}, 32'h12);
        check(last_dev == 5'd5, "R6 device field", {27'h0, last_dev}, 32'd5);
        check(last_fn == 3'd3, "R6 function field", {29'h0, last_fn}, 32'd3);
        check(last_reg == 6'd12, "R6 dword index", {26'h0, last_reg}, 32'd12);
        check(last_be == 4'hF, "R7 full byte enables", {28'h0, last_be}, 32'hF);
        access(1'b1, 6, 2, 32'h0000_BEEF);
        idle();
        check(last_be == 4'hC, "R7 upper-lane byte enables", {28'h0, last_be}, 32'hC);
        check(last_wdata[31:16] == 16'hBEEF, "R7 shifted write data", last_wdata, 32'hBEEF_0000);
        base = req_cnt;
        access(1'b1, 7, 2, 32'h0000_1111);
        idle();
        check(req_cnt == base, "R7 crossing write dropped", req_cnt, base);

        // R8 window reads
        rd(4, 4, 32'hBEEF_F00D, "R8 full window read");
        rd(5, 2, 32'h0000_EFF0, "R8 offset window read");
        idle();
        base = req_cnt;
        rd(7, 2, 32'hFFFF_FFFF, "R8 crossing window read");
        idle();
        check(req_cnt == base, "R8 crossing read issues no request", req_cnt, base);

        // R10 strap
        port_disable = 1'b1;
        rd(0, 4, 32'hFFFF_FFFF, "R10 register read under strap");
        rd(4, 4, 32'hFFFF_FFFF, "R10 window read under strap");
        access(1'b1, 0, 1, 32'h0000_0034);
        idle();
        check(req_cnt == base, "R10 no downstream read", req_cnt, base);
        port_disable = 1'b0;
        rd(0, 4, 32'hFF12_2B34, "R10 write still applied");

        // R11 no response to writes
        access(1'b1, 0, 4, 32'h0000_0000);
        idle();
        check(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 0);
        check(acc_rvalid == 1'b0, "R11 no rvalid after write", {31'h0, acc_rvalid}, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule